// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets clocked logic reach an external 512K x 8 asynchronous static RAM. A client presents one byte request at a time, a read or a write with a 19-bit address, on a valid/ready handshake. The controller then drives the active-low chip select, output enable and write enable strobes, the address bus and a shared tri-state byte bus. Each strobe is held for the number of clock cycles needed to meet the memory's minimum timing.

Every minimum interval is a nanosecond parameter. The controller converts it to cycles by ceiling division against the clock-period parameter and adds one cycle of margin. A read holds chip select and output enable low for the longest access requirement and samples the bus on the edge that ends that window. A write first lowers chip select for one cycle and then frames the write with write enable, which stays low for the longest write requirement. After a read, chip select stays high long enough for the memory to release the bus before the controller can drive it for a write. Every finished access raises a one-cycle done strobe, and a read also returns its byte.

Top module: `sram_bridge`

## Requirements
- R1: After reset, chip select, output enable and write enable are all high (1 = inactive), ready is 1 and done is 0.
- R2: Write enable is never low while chip select is high, and output enable and write enable are never low together. Pin modes: a read is chip select low with output enable low; a write is chip select low with write enable low.
- R3: A write holds chip select low for exactly one cycle with write enable high, then holds write enable low for exactly WR_CYC cycles. WR_CYC is the largest of c(55), c(60), c(60), c(30) and c(70)-1, where c(t) = ceil(t / 10) + 1 at the default 10 ns clock. This gives 7.
- R4: While write enable is low, the address and the driven data stay constant, and the controller drives the data bus only in those cycles. The byte stored is the write request's data.
- R5: A read holds chip select and output enable low together for exactly RD_CYC = max(c(70), c(70), c(35), c(70)) = 8 cycles. The returned byte is the memory content sampled on the edge that ends this window.
- R6: Done is high for exactly one cycle, the first cycle after the access in which chip select is high. Counted in cycles after the accepting edge, that is cycle 1+RD_CYC = 9 for a read and cycle 2+WR_CYC = 9 for a write. Ready is high only while chip select is high.
- R7: After a read, at least HZ_CYC+1 = c(25)+1 = 5 cycles pass between output enable rising and the next write enable falling. The two bus drivers never drive at the same time.
- R8: All 19 address bits reach the memory: bytes written to address 0 and to every single-bit address 2^i (i = 0..18) read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 8 | Read byte, valid with done and held after |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | 19 | Memory address bus |
| mem_data | inout | 8 | Tri-state memory data bus |

## Verification
Two functions can fall into the same window: the memory's release of the bus after a read, and the controller's drive of the bus for the next write. The bench issues a write the moment a read completes, at each of many addresses. Its memory model keeps driving for two cycles after output enable rises. The bench flags any cycle in which both sides drive and measures the gap from output enable rising to write enable falling.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_WSETUP = 3'd1,
        PH_WPULSE = 3'd2,
        PH_RACC   = 3'd3,
        PH_RREL   = 3'd4
    } phase_t;

    typedef struct packed {
        logic cs_n;
        logic oe_n;
        logic we_n;
        logic drive;
    } pins_t;

    localparam pins_t PINS_IDLE = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};

    // nanoseconds to cycles: ceiling plus one margin cycle
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns + 1;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic pins_t pins_for(input phase_t ph);
        pins_t p;
        p = PINS_IDLE;
        case (ph)
            PH_WSETUP: p.cs_n = 1'b0;
            PH_WPULSE: begin p.cs_n = 1'b0; p.we_n = 1'b0; p.drive = 1'b1; end
            PH_RACC:   begin p.cs_n = 1'b0; p.oe_n = 1'b0; end
            default:   p = PINS_IDLE;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_bridge_timer.sv
module sram_bridge_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R3: an expired timer stays expired until reloaded
    p_hold_expired_r3: assert property (@(posedge clk) disable iff (rst)
        (expired && !load) |=> expired);

endmodule

// File: rtl/sram_bridge_pins.sv
module sram_bridge_pins
    import sram_bridge_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_t phase_nxt,
    output pins_t  pins
);
    always_ff @(posedge clk) begin
        if (rst) pins <= PINS_IDLE;
        else     pins <= pins_for(phase_nxt);
    end

    p_we_needs_cs_r2: assert property (@(posedge clk) disable iff (rst)
        !pins.we_n |-> !pins.cs_n);

    p_oe_we_excl_r2: assert property (@(posedge clk) disable iff (rst)
        !(!pins.oe_n && !pins.we_n));

    p_cs_before_we_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(pins.we_n) |-> !$past(pins.cs_n));

endmodule

// File: rtl/sram_bridge_dbus.sv
module sram_bridge_dbus #(
    parameter int DATA_W = 8
) (
    input  logic              drive,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    inout  wire  [DATA_W-1:0] bus
);
    assign bus   = drive ? wdata : {DATA_W{1'bz}};
    assign rdata = bus;
endmodule

// File: rtl/sram_bridge.sv
module sram_bridge
    import sram_bridge_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8,
    parameter int CLK_NS = 10,
    parameter int T_RC   = 70,
    parameter int T_AA   = 70,
    parameter int T_CO   = 70,
    parameter int T_OE   = 35,
    parameter int T_WC   = 70,
    parameter int T_WP   = 55,
    parameter int T_CW   = 60,
    parameter int T_AW   = 60,
    parameter int T_DW   = 30,
    parameter int T_HZ   = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    inout  wire  [DATA_W-1:0] mem_data
);
    localparam int RD_CYC = imax(imax(ns_to_cyc(T_AA, CLK_NS), ns_to_cyc(T_CO, CLK_NS)),
                                 imax(ns_to_cyc(T_OE, CLK_NS), ns_to_cyc(T_RC, CLK_NS)));
    localparam int WR_CYC = imax(imax(imax(ns_to_cyc(T_WP, CLK_NS), ns_to_cyc(T_CW, CLK_NS)),
                                      imax(ns_to_cyc(T_AW, CLK_NS), ns_to_cyc(T_DW, CLK_NS))),
                                 ns_to_cyc(T_WC, CLK_NS) - 1);
    localparam int HZ_CYC = ns_to_cyc(T_HZ, CLK_NS);
    localparam int MAX_CYC = imax(imax(RD_CYC, WR_CYC), HZ_CYC);
    localparam int CNT_W  = $clog2(MAX_CYC + 1);

    phase_t             ph, ph_nxt;
    logic               tmr_load, tmr_expired, capture, fire_done, accept;
    logic [CNT_W-1:0]   tmr_val;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  wdata_q, bus_in;
    pins_t              pins;

    assign accept = (ph == PH_IDLE) && req_valid;

    always_comb begin
        ph_nxt    = ph;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        capture   = 1'b0;
        fire_done = 1'b0;
        case (ph)
            PH_IDLE: if (req_valid) begin
                tmr_load = 1'b1;
                if (req_write) begin
                    ph_nxt  = PH_WSETUP;
                    tmr_val = '0;
                end else begin
                    ph_nxt  = PH_RACC;
                    tmr_val = CNT_W'(RD_CYC - 1);
                end
            end
            PH_WSETUP: if (tmr_expired) begin
                ph_nxt   = PH_WPULSE;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(WR_CYC - 1);
            end
            PH_WPULSE: if (tmr_expired) begin
                ph_nxt    = PH_IDLE;
                fire_done = 1'b1;
            end
            PH_RACC: if (tmr_expired) begin
                ph_nxt    = PH_RREL;
                tmr_load  = 1'b1;
                tmr_val   = CNT_W'(HZ_CYC - 1);
                capture   = 1'b1;
                fire_done = 1'b1;
            end
            PH_RREL: if (tmr_expired) ph_nxt = PH_IDLE;
            default: ph_nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_IDLE;
            addr_q    <= '0;
            wdata_q   <= '0;
            rsp_done  <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            ph       <= ph_nxt;
            rsp_done <= fire_done;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture) rsp_rdata <= bus_in;
        end
    end

    sram_bridge_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired)
    );

    sram_bridge_pins u_pins (
        .clk(clk), .rst(rst), .phase_nxt(ph_nxt), .pins(pins)
    );

    sram_bridge_dbus #(.DATA_W(DATA_W)) u_dbus (
        .drive(pins.drive), .wdata(wdata_q), .rdata(bus_in), .bus(mem_data)
    );

    assign req_ready = (ph == PH_IDLE);
    assign mem_cs_n  = pins.cs_n;
    assign mem_oe_n  = pins.oe_n;
    assign mem_we_n  = pins.we_n;
    assign mem_addr  = addr_q;

    p_addr_stable_r4: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));

    p_wdata_stable_r4: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(wdata_q));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    p_ready_idle_r6: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> mem_cs_n);

    p_done_cs_high_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> mem_cs_n);

endmodule

// File: tb/tb_sram_bridge.sv
module tb_sram_bridge;
    localparam int CLK = 10;
    function automatic int cc(input int ns);
        return (ns + CLK - 1) / CLK + 1;
    endfunction
    localparam int RD_EXP = 8;   // max(c70,c70,c35,c70) = 8
    localparam int WR_EXP = 7;   // max(c55,c60,c60,c30,c70-1) = 7
    localparam int HZ_EXP = 4;   // c25
    localparam int ACC_CYC = 7;  // model: data valid 70 ns after strobes

    logic clk = 0, rst = 1;
    logic req_valid = 0, req_write = 0;
    logic [18:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic req_ready, rsp_done, mem_cs_n, mem_oe_n, mem_we_n;
    logic [7:0] rsp_rdata;
    logic [18:0] mem_addr;
    wire [7:0] mem_data;

    logic sram_drv = 0;
    logic [7:0] sram_val = 8'h00;
    assign mem_data = sram_drv ? sram_val : 8'hzz;

    always #(CLK/2) clk = ~clk;

    sram_bridge dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_cs_n(mem_cs_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
        .mem_data(mem_data)
    );

    int checks = 0, failures = 0;
    bit ended = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // memory model
    logic [7:0] model [logic [18:0]];
    function automatic logic [7:0] model_rd(input logic [18:0] a);
        return model.exists(a) ? model[a] : 8'h00;
    endfunction

    logic p_cs = 1, p_oe = 1, p_we = 1, p_done = 0;
    int we_cnt = 0, rd_cnt = 0, hold = 0, gap = 1000;
    logic [18:0] wa;
    logic [7:0] wd;

    always @(negedge clk) begin
        if (!rst) begin
            if (!mem_we_n) begin
                check(!mem_cs_n, "R2 we low with cs high", mem_cs_n, 0);
                check(mem_oe_n, "R2 oe and we both low", mem_oe_n, 1);
                if (p_we) begin
                    we_cnt = 1; wa = mem_addr; wd = mem_data;
                    check(!p_cs, "R3 cs setup before we", p_cs, 0);
                    check(gap >= HZ_EXP + 1, "R7 turnaround gap", gap, HZ_EXP + 1);
                end else begin
                    we_cnt++;
                    if (mem_addr != wa || mem_data != wd)
                        check(0, "R4 addr/data moved in write", mem_addr, wa);
                end
            end else if (!p_we) begin
                check(we_cnt == WR_EXP, "R3 write pulse cycles", we_cnt, WR_EXP);
                model[wa] = wd;
            end
            if (!mem_cs_n && !mem_oe_n) begin
                rd_cnt++;
                gap = 0;
            end else begin
                if (!p_cs && !p_oe)
                    check(rd_cnt == RD_EXP, "R5 read window cycles", rd_cnt, RD_EXP);
                rd_cnt = 0;
                if (gap < 1000) gap++;
            end
            // memory drives while selected for read, then holds 2 cycles
            if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
                sram_drv = 1; hold = 2;
                sram_val = (rd_cnt >= ACC_CYC) ? model_rd(mem_addr) : 8'hEE;
            end else if (hold > 0) begin
                hold--; sram_drv = 1;
            end else sram_drv = 0;
            if (sram_drv && !mem_we_n) check(0, "R7 bus contention", 1, 0);
            if (rsp_done && p_done) check(0, "R6 done wider than one cycle", 2, 1);
            if (req_ready && !mem_cs_n) check(0, "R6 ready while cs low", 1, 0);
            p_cs = mem_cs_n; p_oe = mem_oe_n; p_we = mem_we_n; p_done = rsp_done;
        end
    end

    task automatic do_req(input bit wr, input logic [18:0] a, input logic [7:0] d,
                          output logic [7:0] q, output int lat);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0; lat = 1;
        while (!rsp_done && lat < 100) begin @(negedge clk); lat++; end
        q = rsp_rdata;
    endtask

    function automatic logic [18:0] addr_of(input int i);
        return (i == 19) ? 19'h0 : (19'h1 << i);
    endfunction

    initial begin
        logic [7:0] q;
        int lat;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(mem_cs_n && mem_oe_n && mem_we_n, "R1 idle pins", {mem_cs_n, mem_oe_n, mem_we_n}, 7);
        check(req_ready == 1, "R1 ready after reset", req_ready, 1);
        check(rsp_done == 0, "R1 done after reset", rsp_done, 0);

        for (int i = 0; i < 20; i++) begin
            do_req(1, addr_of(i), 8'(i * 29 + 3), q, lat);
            check(lat == 2 + WR_EXP, "R6 write done cycle", lat, 2 + WR_EXP);
        end
        for (int i = 19; i >= 0; i--) begin
            do_req(0, addr_of(i), 8'h00, q, lat);
            check(lat == 1 + RD_EXP, "R6 read done cycle", lat, 1 + RD_EXP);
            check(q == 8'(i * 29 + 3), "R8 read back", q, 8'(i * 29 + 3));
        end
        // read immediately followed by write to the same address
        for (int i = 0; i < 20; i++) begin
            do_req(0, addr_of(i), 8'h00, q, lat);
            check(q == 8'(i * 29 + 3), "R5 read before turnaround", q, 8'(i * 29 + 3));
            do_req(1, addr_of(i), 8'(~(i * 13)), q, lat);
            do_req(0, addr_of(i), 8'h00, q, lat);
            check(q == 8'(~(i * 13)), "R4 written byte stored", q, 8'(~(i * 13)));
        end
        repeat (5) @(negedge clk);
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            checks++; failures++;
            $display("FAIL watchdog act=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule